// File: doc/BRIEF.md
# Program RAM Boot Loader

This block fills on-chip program RAM from a slow, byte-wide external memory right after reset. While reset is asserted it samples a map-mode input and a page-select input. With map mode 0, internal RAM is the lowest 2K words of the 16K-word program space. The loader then reads one image from the byte memory and keeps the core in reset until every word has been written. With map mode 1, internal RAM is the highest 2K words, starting at 0x3800. No boot takes place in that mode, and the core is released at once.

Each external access holds the byte address and the read strobe for a fixed number of wait states plus one cycle. The byte is taken on the final cycle. Three bytes arrive least significant first and form one 24-bit word, which goes to the RAM write port. Once the core runs, its program-space accesses are decoded against the sampled map. Hits go to the RAM port, and all other addresses are flagged as external.

Top module: `pm_boot_loader`

## Requirements
- R1: `map_mode` and `page_sel` are captured while `rst_n` is low, and later changes have no effect. With mode 0, `core_hold` is 1 during reset and `boot_rd` is 1 in the first cycle after release.
- R2: With mode 1, `boot_rd` never asserts, no RAM write occurs, `boot_done` never pulses, and `core_hold` is 0 from the first cycle after release.
- R3: Byte addresses are `page*BOOT_WORDS*3 + n`, with n going up from 0 to `3*BOOT_WORDS-1`, one value per access.
- R4: Each access keeps `boot_rd` high and `boot_addr` stable for exactly WAIT_ST+1 cycles (4 by default). `boot_data` is taken only in the last of these cycles.
- R5: Word k is {byte 3k+2, byte 3k+1, byte 3k}, bits 23:16 / 15:8 / 7:0. It is written to RAM index k in the cycle after its third byte is taken, and indices go up.
- R6: `core_hold` stays 1 through the cycle of the final loader write. `boot_done` is a one-cycle pulse in the first cycle with `core_hold` at 0.
- R7: With mode 0 and the core running, a core address below 0x800 sets `core_int_sel` and gives `ram_addr` = address[10:0]. Any other address sets `core_ext_sel`.
- R8: With mode 1 and the core running, a core address at or above 0x3800 sets `core_int_sel` and gives `ram_addr` = address − 0x3800. Any lower address sets `core_ext_sel`.
- R9: A core write reaches `ram_we` only when it hits internal RAM and `core_hold` is 0. Core writes made while `core_hold` is 1 are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_mode | input | 1 | Memory map select, sampled in reset |
| page_sel | input | 3 | Boot image select, sampled in reset |
| boot_addr | output | 16 | External byte address |
| boot_rd | output | 1 | External read strobe |
| boot_data | input | 8 | External byte data |
| core_addr | input | 14 | Core program-space address |
| core_we | input | 1 | Core program-space write |
| core_wdata | input | 24 | Core write data |
| core_hold | output | 1 | Keeps the core in reset while high |
| boot_done | output | 1 | One-cycle pulse at the end of a boot |
| core_int_sel | output | 1 | Core address falls in internal RAM |
| core_ext_sel | output | 1 | Core address falls in external memory |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 11 | RAM word index |
| ram_wdata | output | 24 | RAM write data |

## Verification
The loader's last word write and a pending core write can target the RAM port in the same cycle. The bench provokes this by holding a core write to an internal address for the whole boot. It then judges the outcome from the RAM writes seen at the port: exactly one loader write per image word while the core is held, then the core's write landing in the first released cycle, together with the done pulse. The external memory model returns junk bytes on every strobe cycle except the last, so sampling before the wait states expire corrupts the image check.

// File: rtl/pmbl_pkg.sv
package pmbl_pkg;

  typedef enum logic [1:0] {
    ST_LATCH = 2'd0,
    ST_FETCH = 2'd1,
    ST_FLUSH = 2'd2,
    ST_RUN   = 2'd3
  } ld_state_e;

  // first byte of an image inside the boot memory
  function automatic int unsigned image_base(int unsigned page, int unsigned words,
                                             int unsigned bytes_per_word);
    return page * words * bytes_per_word;
  endfunction

  // bytes taken per image
  function automatic int unsigned image_span(int unsigned words, int unsigned bytes_per_word);
    return words * bytes_per_word;
  endfunction

endpackage

// File: rtl/pmbl_seq.sv
module pmbl_seq
  import pmbl_pkg::*;
#(
  parameter int BOOT_WORDS = 2048,
  parameter int BPW        = 3,
  parameter int WAIT_ST    = 3,
  parameter int PG_W       = 3,
  parameter int BA_W       = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            map_mode,
  input  logic [PG_W-1:0] page_sel,
  output logic [BA_W-1:0] boot_addr,
  output logic            boot_rd,
  output logic            sample,
  output logic            mode_q,
  output logic            busy,
  output logic            done
);
  localparam int TOTAL = image_span(BOOT_WORDS, BPW);
  localparam int OFF_W = $clog2(TOTAL);
  localparam int WC_W  = $clog2(WAIT_ST + 2);

  ld_state_e       state_q;
  logic [PG_W-1:0] page_q;
  logic [OFF_W-1:0] off_q;
  logic [WC_W-1:0] wcnt_q;
  logic            done_q;
  logic            last_byte;

  assign boot_rd   = (state_q == ST_FETCH);
  assign sample    = boot_rd && (wcnt_q == WC_W'(WAIT_ST));
  assign last_byte = sample && (off_q == OFF_W'(TOTAL - 1));
  assign busy      = (state_q != ST_RUN);
  assign done      = done_q;
  assign boot_addr = BA_W'(image_base(int'(page_q), BOOT_WORDS, BPW)) + BA_W'(off_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LATCH;
      mode_q  <= map_mode;
      page_q  <= page_sel;
      off_q   <= '0;
      wcnt_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_LATCH: begin
          state_q <= mode_q ? ST_RUN : ST_FETCH;
          off_q   <= '0;
          wcnt_q  <= '0;
        end
        ST_FETCH: begin
          if (sample) begin
            wcnt_q <= '0;
            if (last_byte) state_q <= ST_FLUSH;
            else           off_q   <= off_q + 1'b1;
          end else begin
            wcnt_q <= wcnt_q + 1'b1;
          end
        end
        ST_FLUSH: begin
          state_q <= ST_RUN;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  // R4: address and strobe do not move inside an access
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_rd && wcnt_q != '0) |-> ($stable(boot_addr) && $past(boot_rd)));

  // R2: map mode 1 never touches the boot memory
  p_no_fetch_mode1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> !boot_rd);

  // R6: completion is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

endmodule

// File: rtl/pmbl_pack.sv
module pmbl_pack #(
  parameter int BPW        = 3,
  parameter int BYTE_W     = 8,
  parameter int WORD_W     = 24,
  parameter int RA_W       = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              ld_we,
  output logic [RA_W-1:0]   ld_addr,
  output logic [WORD_W-1:0] ld_data
);
  localparam int LN_W = $clog2(BPW + 1);

  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] merged;
  logic [LN_W-1:0]   lane_q;
  logic [RA_W-1:0]   widx_q;
  logic              we_q;
  logic [RA_W-1:0]   addr_q;
  logic [WORD_W-1:0] data_q;
  logic              word_full;

  // place the incoming byte in its lane, lowest lane first
  always_comb begin
    merged = acc_q;
    merged[int'(lane_q) * BYTE_W +: BYTE_W] = byte_in;
  end

  assign word_full = sample && (lane_q == LN_W'(BPW - 1));
  assign ld_we     = we_q;
  assign ld_addr   = addr_q;
  assign ld_data   = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      lane_q <= '0;
      widx_q <= '0;
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      we_q <= 1'b0;
      if (word_full) begin
        acc_q  <= '0;
        lane_q <= '0;
        we_q   <= 1'b1;
        data_q <= merged;
        addr_q <= widx_q;
        widx_q <= widx_q + 1'b1;
      end else if (sample) begin
        acc_q  <= merged;
        lane_q <= lane_q + 1'b1;
      end
    end
  end

  // R5: a word leaves only once all its lanes are consumed
  p_lane_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we |-> (lane_q == '0));

endmodule

// File: rtl/pmbl_map.sv
module pmbl_map #(
  parameter int PM_AW     = 14,
  parameter int RA_W      = 11,
  parameter int WORD_W    = 24,
  parameter int RAM_WORDS = 2048,
  parameter int HI_BASE   = 'h3800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_q,
  input  logic              busy,
  input  logic [PM_AW-1:0]  core_addr,
  input  logic              core_we,
  input  logic [WORD_W-1:0] core_wdata,
  input  logic              ld_we,
  input  logic [RA_W-1:0]   ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  output logic              int_sel,
  output logic              ext_sel,
  output logic              ram_we,
  output logic [RA_W-1:0]   ram_addr,
  output logic [WORD_W-1:0] ram_wdata
);
  logic [PM_AW-1:0] base_v;
  logic [PM_AW-1:0] rel;
  logic             hit;

  // below the window the difference wraps high and misses
  assign base_v  = mode_q ? PM_AW'(HI_BASE) : '0;
  assign rel     = core_addr - base_v;
  assign hit     = (rel < PM_AW'(RAM_WORDS));
  assign int_sel = !busy && hit;
  assign ext_sel = !busy && !hit;

  always_comb begin
    if (ld_we) begin
      ram_we    = 1'b1;
      ram_addr  = ld_addr;
      ram_wdata = ld_data;
    end else begin
      ram_we    = core_we && int_sel;
      ram_addr  = rel[RA_W-1:0];
      ram_wdata = core_wdata;
    end
  end

  // R9: while the core is held only the loader writes
  p_core_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ld_we) |-> !ram_we);

endmodule

// File: rtl/pm_boot_loader.sv
module pm_boot_loader #(
  parameter int BYTE_W     = 8,
  parameter int WORD_W     = 24,
  parameter int RAM_WORDS  = 2048,
  parameter int BOOT_WORDS = 2048,
  parameter int PAGES      = 8,
  parameter int WAIT_ST    = 3,
  parameter int PM_AW      = 14,
  parameter int HI_BASE    = 'h3800,
  localparam int BPW  = WORD_W / BYTE_W,
  localparam int RA_W = $clog2(RAM_WORDS),
  localparam int PG_W = $clog2(PAGES),
  localparam int BA_W = $clog2(PAGES * BOOT_WORDS * BPW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_mode,
  input  logic [PG_W-1:0]   page_sel,
  output logic [BA_W-1:0]   boot_addr,
  output logic              boot_rd,
  input  logic [BYTE_W-1:0] boot_data,
  input  logic [PM_AW-1:0]  core_addr,
  input  logic              core_we,
  input  logic [WORD_W-1:0] core_wdata,
  output logic              core_hold,
  output logic              boot_done,
  output logic              core_int_sel,
  output logic              core_ext_sel,
  output logic              ram_we,
  output logic [RA_W-1:0]   ram_addr,
  output logic [WORD_W-1:0] ram_wdata
);
  logic              sample;
  logic              mode_q;
  logic              busy;
  logic              ld_we;
  logic [RA_W-1:0]   ld_addr;
  logic [WORD_W-1:0] ld_data;

  pmbl_seq #(
    .BOOT_WORDS(BOOT_WORDS), .BPW(BPW), .WAIT_ST(WAIT_ST),
    .PG_W(PG_W), .BA_W(BA_W)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .map_mode(map_mode), .page_sel(page_sel),
    .boot_addr(boot_addr), .boot_rd(boot_rd), .sample(sample),
    .mode_q(mode_q), .busy(busy), .done(boot_done)
  );

  pmbl_pack #(
    .BPW(BPW), .BYTE_W(BYTE_W), .WORD_W(WORD_W), .RA_W(RA_W)
  ) pack_i (
    .clk(clk), .rst_n(rst_n), .sample(sample), .byte_in(boot_data),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  pmbl_map #(
    .PM_AW(PM_AW), .RA_W(RA_W), .WORD_W(WORD_W),
    .RAM_WORDS(RAM_WORDS), .HI_BASE(HI_BASE)
  ) map_i (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .busy(busy),
    .core_addr(core_addr), .core_we(core_we), .core_wdata(core_wdata),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .int_sel(core_int_sel), .ext_sel(core_ext_sel),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  assign core_hold = busy;

  // R6: completion follows the final loader write and frees the core
  p_done_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    boot_done |-> ($past(ld_we) && !core_hold));

endmodule

// File: tb/pm_boot_loader_tb_top.sv
module pm_boot_loader_tb_top;
  localparam int WORDS = 8;
  localparam int WAITS = 3;
  localparam int NPG   = 8;
  localparam int TOT   = WORDS * 3;
  localparam int BAW   = $clog2(NPG * TOT);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic map_mode = 1'b0;
  logic [2:0] page_sel = '0;
  logic [BAW-1:0] boot_addr;
  logic boot_rd;
  logic [7:0] boot_data = '0;
  logic [13:0] core_addr = '0;
  logic core_we = 1'b0;
  logic [23:0] core_wdata = '0;
  logic core_hold, boot_done, core_int_sel, core_ext_sel, ram_we;
  logic [10:0] ram_addr;
  logic [23:0] ram_wdata;

  pm_boot_loader #(.BOOT_WORDS(WORDS), .WAIT_ST(WAITS)) dut_i (
    .clk(clk), .rst_n(rst_n), .map_mode(map_mode), .page_sel(page_sel),
    .boot_addr(boot_addr), .boot_rd(boot_rd), .boot_data(boot_data),
    .core_addr(core_addr), .core_we(core_we), .core_wdata(core_wdata),
    .core_hold(core_hold), .boot_done(boot_done),
    .core_int_sel(core_int_sel), .core_ext_sel(core_ext_sel),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit summary_done = 0;
  logic [7:0] salt = 8'h5a;

  logic [23:0] ram_m [0:2047];
  int run_len = 0, exp_off = 0, exp_idx = 0, run_pg = 0;
  logic prev_rd = 1'b0;
  logic [BAW-1:0] prev_addr = '0;
  int ld_writes = 0, rd_cycles = 0, done_cnt = 0, cyc = 0, last_we_cyc = -10;

  function automatic logic [7:0] img_byte(int pg, int off);
    return 8'(pg * 61 + off * 29 + int'(salt)) ^ 8'(off >> 2);
  endfunction

  function automatic logic [23:0] exp_word(int pg, int k);
    return {img_byte(pg, 3*k+2), img_byte(pg, 3*k+1), img_byte(pg, 3*k)};
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  // external byte memory model and RAM port observer
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      run_len = 0; prev_rd = 1'b0; exp_off = 0; exp_idx = 0;
    end else begin
      if (boot_rd) begin
        rd_cycles++;
        if (prev_rd && boot_addr == prev_addr) run_len++;
        else begin
          if (prev_rd) chk(run_len == WAITS + 1, "R4 strobe length", run_len, WAITS + 1);
          chk(int'(boot_addr) == run_pg * TOT + exp_off, "R3 byte address",
              boot_addr, run_pg * TOT + exp_off);
          exp_off++;
          run_len = 1;
        end
      end else if (prev_rd) begin
        chk(run_len == WAITS + 1, "R4 strobe length", run_len, WAITS + 1);
      end
      // only the final strobe cycle carries the real byte
      boot_data = (boot_rd && run_len == WAITS + 1) ?
                  img_byte(run_pg, int'(boot_addr) - run_pg * TOT) : 8'($urandom);
      prev_rd = boot_rd;
      prev_addr = boot_addr;
      if (boot_done) begin
        done_cnt++;
        chk(!core_hold, "R6 hold at done", core_hold, 0);
        chk(last_we_cyc == cyc - 1, "R6 done after last write", last_we_cyc, cyc - 1);
      end
      if (ram_we) begin
        ram_m[ram_addr] = ram_wdata;
        last_we_cyc = cyc;
        if (core_hold) begin
          ld_writes++;
          chk(int'(ram_addr) == exp_idx, "R5 word index", ram_addr, exp_idx);
          chk(ram_wdata == exp_word(run_pg, exp_idx), "R5 word value",
              ram_wdata, exp_word(run_pg, exp_idx));
          exp_idx++;
        end
      end
    end
  end

  task automatic do_reset(bit mode, int pg);
    rst_n = 1'b0; map_mode = mode; page_sel = 3'(pg); run_pg = pg;
    repeat (3) @(negedge clk);
    chk(core_hold == 1'b1, "R1 hold in reset", core_hold, 1);
    chk(boot_rd == 1'b0, "R1 no strobe in reset", boot_rd, 0);
    chk(boot_done == 1'b0 && ram_we == 1'b0, "R1 quiet in reset", {boot_done, ram_we}, 0);
    ld_writes = 0; rd_cycles = 0; done_cnt = 0;
    rst_n = 1'b1;
    @(negedge clk);
    // R1/R3: inputs moved after release must be ignored
    map_mode = ~mode;
    page_sel = 3'(pg + 3);
  endtask

  task automatic boot_run(int pg, bit core_poke);
    if (core_poke) begin
      core_addr = 14'd3; core_we = 1'b1; core_wdata = 24'hABCDEF;
    end
    do_reset(1'b0, pg);
    chk(boot_rd == 1'b1, "R1 boot starts", boot_rd, 1);
    chk(core_hold == 1'b1, "R1 hold during boot", core_hold, 1);
    for (int i = 0; i < TOT * (WAITS + 1) + 20 && done_cnt == 0; i++) @(negedge clk);
    core_we = 1'b0;
    repeat (4) @(negedge clk);
    chk(done_cnt == 1, "R6 single done pulse", done_cnt, 1);
    chk(ld_writes == WORDS, "R5 loader write count", ld_writes, WORDS);
    chk(rd_cycles == TOT * (WAITS + 1), "R4 strobe cycles", rd_cycles, TOT * (WAITS + 1));
    chk(boot_rd == 1'b0, "R6 strobe off after boot", boot_rd, 0);
    for (int k = 0; k < WORDS; k++) begin
      if (core_poke && k == 3)
        chk(ram_m[k] == 24'hABCDEF, "R9 core write after release", ram_m[k], 24'hABCDEF);
      else
        chk(ram_m[k] == exp_word(pg, k), "R5 image word", ram_m[k], exp_word(pg, k));
    end
  endtask

  task automatic decode_run(bit mode);
    for (int i = 0; i < 40; i++) begin
      int a;
      bit hit, we;
      case (i)
        0: a = 0; 1: a = 'h7FF; 2: a = 'h800; 3: a = 'h37FF; 4: a = 'h3800; 5: a = 'h3FFF;
        default: a = int'($urandom_range(0, 'h3FFF));
      endcase
      we = 1'($urandom);
      core_addr = 14'(a); core_we = we; core_wdata = 24'($urandom);
      #2;
      hit = mode ? (a >= 'h3800) : (a < 'h800);
      chk(core_int_sel == hit, mode ? "R8 internal select" : "R7 internal select", core_int_sel, hit);
      chk(core_ext_sel == !hit, mode ? "R8 external select" : "R7 external select", core_ext_sel, !hit);
      if (hit)
        chk(int'(ram_addr) == (a & 'h7FF), mode ? "R8 ram index" : "R7 ram index", ram_addr, a & 'h7FF);
      chk(ram_we == (we && hit), "R9 core write gating", ram_we, we && hit);
      @(negedge clk);
    end
    core_we = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    salt = 8'($urandom);
    boot_run(5, 1'b1);
    decode_run(1'b0);
    boot_run(7, 1'b0);
    boot_run(0, 1'b0);
    boot_run(int'($urandom_range(1, 6)), 1'b0);
    // map mode 1: no boot at all
    do_reset(1'b1, 2);
    chk(core_hold == 1'b0, "R2 released at once", core_hold, 0);
    repeat (60) @(negedge clk);
    chk(rd_cycles == 0, "R2 no strobes", rd_cycles, 0);
    chk(ld_writes == 0, "R2 no loader writes", ld_writes, 0);
    chk(done_cnt == 0, "R2 no done pulse", done_cnt, 0);
    decode_run(1'b1);
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

endmodule